// File: doc/BRIEF.md
# Stereo Gliding Attenuator with Soft Mute

This block is the digital volume stage of a stereo PCM path. Every sample-rate strobe carries one signed left word and one signed right word. Each channel is scaled by a gain chosen through its own 8-bit attenuation code. Code 255 is unity gain, each lower code is 0.5 dB quieter, and code 0 is silence. The gain is applied as a fixed-point multiply followed by rounding and saturation. The gain values come from a constant table that is computed at elaboration.

A new code does not take effect at once. Each channel keeps a present gain index that walks toward the requested code one step at a time, so a volume change never jumps. A 2-bit speed select stretches each step over 1, 2, 4 or 8 strobes. A soft-mute control fades both channels linearly to zero over 8192 strobes and fades them back over the same span. A flag reports when the fade has reached silence.

Top module: `attn_softmute`

## Requirements
- R1: After reset both present indices and both targets act as code 255 (unity), mute is off with the fade at full scale, the outputs, the output-valid pulse and the mute-done flag are 0, and the first sample passes through unchanged.
- R2: With the present index at k ≥ 1, the gain is G(k) = round(2^20 · 10^(−(255−k)/40)), so each step is 0.5 dB and 255 is exactly 2^20. Index 0 gives G = 0, which makes the output zero for any input.
- R3: Each output equals floor((x · E + 2^19) / 2^20), saturated to the signed 24-bit range, where x is the input sample and E = floor(G · m / 8192) with m the fade count.
- R4: With speed select 0, the present index moves exactly one step toward the code on every strobe until it is equal to the code. A sample uses the index and fade count held just before its own strobe.
- R5: With speed select s, the index moves one step on every 2^s-th strobe while it differs from the code. The strobe counter restarts whenever the index equals the code.
- R6: A code change during a glide continues from the present index toward the new code, with no jump.
- R7: While soft mute is high, the fade count m (initially 8192) drops by one on each strobe until it reaches 0.
- R8: The mute-done flag rises after the strobe that brings m to 0 and stays high while m is 0.
- R9: While soft mute is low, m rises by one per strobe up to 8192. The mute-done flag falls on the first such strobe.
- R10: Toggling soft mute in the middle of a fade reverses the ramp from the present count.
- R11: Results appear with the output-valid pulse 3 clocks after the strobe. Outputs hold between pulses. The index and the fade count change only on strobes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| smp_stb | input | 1 | One-cycle sample strobe at the frame rate |
| smp_l_in | input | 24 | Left input sample, signed |
| smp_r_in | input | 24 | Right input sample, signed |
| att_l | input | 8 | Left attenuation code (255 = 0 dB, 0 = silent) |
| att_r | input | 8 | Right attenuation code |
| soft_mute | input | 1 | High fades to silence, low fades back |
| glide_sel | input | 2 | Strobes per index step = 2^glide_sel |
| smp_l_out | output | 24 | Left attenuated sample, signed |
| smp_r_out | output | 24 | Right attenuated sample, signed |
| smp_out_vld | output | 1 | Pulses when output samples update |
| mute_done | output | 1 | High while the fade is at silence |

## Verification
The samples include full-scale positive and negative words, small odd values and mixed signs. Small odd values expose rounding and sign-shift errors, and the extreme words expose width and saturation mistakes. The two channels are given different codes so that a swapped or shared index shows up. Each glide is followed strobe by strobe at several speed selects, which separates an off-by-one step period from a correct one. The fade is run through its full descent, its full recovery and a mid-ramp reversal, which pins down the exact strobe on which the done flag changes.

// File: rtl/attn_pkg.sv
package attn_pkg;

  // Gain for index idx on a 0.5 dB grid, top index = unity (2^frac).
  function automatic longint gain_of(input int unsigned idx,
                                     input int unsigned max_idx,
                                     input int unsigned frac);
    real g;
    if (idx == 0) return 0;
    g = (2.0 ** frac) * (10.0 ** (-(real'(max_idx) - real'(idx)) / 40.0));
    return longint'($rtoi(g + 0.5));
  endfunction

endpackage

// File: rtl/attn_gain_rom.sv
module attn_gain_rom #(
  parameter int IDX_W  = 8,
  parameter int FRAC   = 20,
  parameter int GAIN_W = FRAC + 1
) (
  input  logic              clk,
  input  logic              en,
  input  logic [IDX_W-1:0]  idx,
  output logic [GAIN_W-1:0] gain
);
  localparam int DEPTH = 1 << IDX_W;

  logic [GAIN_W-1:0] rom [DEPTH];

  // R2: table filled from the 0.5 dB law at elaboration
  initial begin
    for (int i = 0; i < DEPTH; i++)
      rom[i] = GAIN_W'(attn_pkg::gain_of(i, DEPTH - 1, FRAC));
  end

  always_ff @(posedge clk) begin
    if (en) gain <= rom[idx];
  end
endmodule

// File: rtl/attn_glide.sv
module attn_glide #(
  parameter int IDX_W   = 8,
  parameter int SPEED_W = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               step,
  input  logic [IDX_W-1:0]   target,
  input  logic [SPEED_W-1:0] speed,
  output logic [IDX_W-1:0]   cur
);
  localparam int DIV_W = (1 << SPEED_W) - 1;
  localparam logic [IDX_W-1:0] TOP = '1;

  logic [DIV_W-1:0] cnt;
  logic [DIV_W:0]   period;
  logic             last;

  assign period = (DIV_W + 1)'(1) << speed;
  assign last   = (({1'b0, cnt} + 1'b1) >= period);

  // R4 R5 R6: one step toward target per 2^speed strobes
  always_ff @(posedge clk) begin
    if (rst) begin
      cur <= TOP;
      cnt <= '0;
    end else if (step) begin
      if (cur == target) begin
        cnt <= '0;
      end else if (last) begin
        cnt <= '0;
        cur <= (cur < target) ? cur + 1'b1 : cur - 1'b1;
      end else begin
        cnt <= cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/attn_mute_ramp.sv
module attn_mute_ramp #(
  parameter int SPAN_LOG2 = 13,
  parameter int CW        = SPAN_LOG2 + 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          step,
  input  logic          mute,
  output logic [CW-1:0] cnt,
  output logic          done
);
  localparam logic [CW-1:0] FULL = CW'(1) << SPAN_LOG2;

  logic [CW-1:0] nxt;

  // R7 R9 R10: linear fade count, reversible at any point
  always_comb begin
    nxt = cnt;
    if (mute && cnt != '0)        nxt = cnt - 1'b1;
    else if (!mute && cnt != FULL) nxt = cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt  <= FULL;
      done <= 1'b0;
    end else if (step) begin
      cnt  <= nxt;
      done <= (nxt == '0);  // R8
    end
  end
endmodule

// File: rtl/attn_scaler.sv
module attn_scaler #(
  parameter int DATA_W    = 24,
  parameter int FRAC      = 20,
  parameter int GAIN_W    = FRAC + 1,
  parameter int SPAN_LOG2 = 13,
  parameter int CW        = SPAN_LOG2 + 1
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     v0,
  input  logic signed [DATA_W-1:0] s0,
  input  logic [GAIN_W-1:0]        gain0,
  input  logic [CW-1:0]            m0,
  output logic signed [DATA_W-1:0] out,
  output logic                     vout
);
  localparam int WW = GAIN_W + CW;
  localparam int PW = DATA_W + GAIN_W + 1;
  localparam logic signed [PW-1:0] MAXV = (PW'(1) <<< (DATA_W - 1)) - 1;
  localparam logic signed [PW-1:0] MINV = -MAXV - 1;
  localparam logic signed [PW-1:0] HALF = PW'(1) <<< (FRAC - 1);

  logic [WW-1:0]            wide;
  logic [GAIN_W-1:0]        eff;
  logic signed [DATA_W-1:0] s1;
  logic                     v1;
  logic signed [PW-1:0]     a, b, prod, shf;
  logic signed [DATA_W-1:0] sat;

  assign wide = WW'(gain0) * WW'(m0);

  // R3: multiply, round half up, arithmetic shift, saturate
  always_comb begin
    a    = PW'(s1);
    b    = PW'({1'b0, eff});
    prod = a * b;
    shf  = (prod + HALF) >>> FRAC;
    if (shf > MAXV)      sat = MAXV[DATA_W-1:0];
    else if (shf < MINV) sat = MINV[DATA_W-1:0];
    else                 sat = shf[DATA_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1   <= 1'b0;
      vout <= 1'b0;
      eff  <= '0;
      s1   <= '0;
      out  <= '0;
    end else begin
      v1   <= v0;
      vout <= v1;
      if (v0) begin
        eff <= GAIN_W'(wide >> SPAN_LOG2);
        s1  <= s0;
      end
      if (v1) out <= sat;
    end
  end
endmodule

// File: rtl/attn_softmute.sv
module attn_softmute #(
  parameter int DATA_W    = 24,
  parameter int CODE_W    = 8,
  parameter int FRAC      = 20,
  parameter int SPEED_W   = 2,
  parameter int SPAN_LOG2 = 13
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     smp_stb,
  input  logic signed [DATA_W-1:0] smp_l_in,
  input  logic signed [DATA_W-1:0] smp_r_in,
  input  logic [CODE_W-1:0]        att_l,
  input  logic [CODE_W-1:0]        att_r,
  input  logic                     soft_mute,
  input  logic [SPEED_W-1:0]       glide_sel,
  output logic signed [DATA_W-1:0] smp_l_out,
  output logic signed [DATA_W-1:0] smp_r_out,
  output logic                     smp_out_vld,
  output logic                     mute_done
);
  localparam int GAIN_W = FRAC + 1;
  localparam int CW     = SPAN_LOG2 + 1;
  localparam int NCH    = 2;

  logic signed [DATA_W-1:0] din  [NCH];
  logic signed [DATA_W-1:0] dout [NCH];
  logic [CODE_W-1:0]        tgt  [NCH];
  logic [CODE_W-1:0]        cur_idx [NCH];
  logic [NCH-1:0]           vld_ch;
  logic [CW-1:0]            mute_cnt;
  logic                     v0;
  logic [CW-1:0]            m0;

  assign din[0] = smp_l_in;
  assign din[1] = smp_r_in;
  assign tgt[0] = att_l;
  assign tgt[1] = att_r;

  attn_mute_ramp #(.SPAN_LOG2(SPAN_LOG2), .CW(CW)) u_ramp (
    .clk(clk), .rst(rst), .step(smp_stb), .mute(soft_mute),
    .cnt(mute_cnt), .done(mute_done)
  );

  // stage 0: capture the fade count in force before this strobe
  always_ff @(posedge clk) begin
    if (rst) begin
      v0 <= 1'b0;
      m0 <= '0;
    end else begin
      v0 <= smp_stb;
      if (smp_stb) m0 <= mute_cnt;
    end
  end

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    logic [GAIN_W-1:0]        gain0;
    logic signed [DATA_W-1:0] s0;

    always_ff @(posedge clk) begin
      if (rst) s0 <= '0;
      else if (smp_stb) s0 <= din[c];
    end

    attn_glide #(.IDX_W(CODE_W), .SPEED_W(SPEED_W)) u_glide (
      .clk(clk), .rst(rst), .step(smp_stb), .target(tgt[c]),
      .speed(glide_sel), .cur(cur_idx[c])
    );

    attn_gain_rom #(.IDX_W(CODE_W), .FRAC(FRAC), .GAIN_W(GAIN_W)) u_rom (
      .clk(clk), .en(smp_stb), .idx(cur_idx[c]), .gain(gain0)
    );

    attn_scaler #(.DATA_W(DATA_W), .FRAC(FRAC), .GAIN_W(GAIN_W),
                  .SPAN_LOG2(SPAN_LOG2), .CW(CW)) u_scale (
      .clk(clk), .rst(rst), .v0(v0), .s0(s0), .gain0(gain0), .m0(m0),
      .out(dout[c]), .vout(vld_ch[c])
    );
  end

  assign smp_l_out   = dout[0];
  assign smp_r_out   = dout[1];
  assign smp_out_vld = &vld_ch;
endmodule

// File: rtl/attn_softmute_chk.sv
module attn_softmute_chk #(
  parameter int DATA_W    = 24,
  parameter int IDX_W     = 8,
  parameter int SPAN_LOG2 = 13,
  parameter int CW        = SPAN_LOG2 + 1
) (
  input logic              clk,
  input logic              rst,
  input logic              in_stb,
  input logic              out_vld,
  input logic [DATA_W-1:0] out_l,
  input logic [DATA_W-1:0] out_r,
  input logic [IDX_W-1:0]  cur_l,
  input logic [IDX_W-1:0]  cur_r,
  input logic [CW-1:0]     mute_cnt,
  input logic              soft_mute,
  input logic              mute_done
);
  localparam logic [CW-1:0] FULL = CW'(1) << SPAN_LOG2;

  assert_latency_R11: assert property (@(posedge clk) disable iff (rst)
    in_stb |-> ##3 out_vld);

  assert_hold_R11: assert property (@(posedge clk) disable iff (rst)
    !out_vld |-> ($stable(out_l) && $stable(out_r)));

  assert_step_l_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_l != $past(cur_l)) |->
      ($past(in_stb) && ((cur_l == IDX_W'($past(cur_l) + 1'b1)) ||
                         (cur_l == IDX_W'($past(cur_l) - 1'b1)))));

  assert_step_r_R4: assert property (@(posedge clk) disable iff (rst)
    (cur_r != $past(cur_r)) |->
      ($past(in_stb) && ((cur_r == IDX_W'($past(cur_r) + 1'b1)) ||
                         (cur_r == IDX_W'($past(cur_r) - 1'b1)))));

  assert_mute_range_R7: assert property (@(posedge clk) disable iff (rst)
    mute_cnt <= FULL);

  assert_mute_done_R8: assert property (@(posedge clk) disable iff (rst)
    $rose(mute_done) |-> $past(soft_mute));

  assert_mute_move_R9: assert property (@(posedge clk) disable iff (rst)
    (mute_cnt != $past(mute_cnt)) |-> $past(in_stb));
endmodule

bind attn_softmute attn_softmute_chk #(
  .DATA_W(DATA_W), .IDX_W(CODE_W), .SPAN_LOG2(SPAN_LOG2), .CW(SPAN_LOG2 + 1)
) u_chk (
  .clk(clk), .rst(rst), .in_stb(smp_stb), .out_vld(smp_out_vld),
  .out_l(smp_l_out), .out_r(smp_r_out), .cur_l(cur_idx[0]),
  .cur_r(cur_idx[1]), .mute_cnt(mute_cnt), .soft_mute(soft_mute),
  .mute_done(mute_done)
);

// File: tb/attn_softmute_tb.sv
module attn_softmute_tb;
  localparam int DATA_W = 24;
  localparam int FRAC   = 20;
  localparam int SPAN   = 8192;

  logic clk = 0;
  logic rst = 1;
  logic smp_stb = 0;
  logic signed [DATA_W-1:0] smp_l_in = '0, smp_r_in = '0;
  logic [7:0] att_l = 8'hFF, att_r = 8'hFF;
  logic soft_mute = 0;
  logic [1:0] glide_sel = 2'd0;
  logic signed [DATA_W-1:0] smp_l_out, smp_r_out;
  logic smp_out_vld, mute_done;

  int n_chk = 0, n_fail = 0;

  // reference state, built from the requirements
  int cur_ref[2], div_ref[2], m_ref;

  always #5 clk = ~clk;

  attn_softmute u_dut (
    .clk(clk), .rst(rst), .smp_stb(smp_stb), .smp_l_in(smp_l_in),
    .smp_r_in(smp_r_in), .att_l(att_l), .att_r(att_r),
    .soft_mute(soft_mute), .glide_sel(glide_sel), .smp_l_out(smp_l_out),
    .smp_r_out(smp_r_out), .smp_out_vld(smp_out_vld), .mute_done(mute_done)
  );

  function automatic longint gain_ref(int idx);
    if (idx == 0) return 0;
    return longint'($rtoi((2.0 ** FRAC) * (10.0 ** (-(255.0 - real'(idx)) / 40.0)) + 0.5));
  endfunction

  function automatic longint out_ref(longint x, int idx, int m);
    longint e, p, o;
    e = (gain_ref(idx) * m) >> 13;
    p = x * e;
    o = (p + (64'sd1 <<< (FRAC - 1))) >>> FRAC;
    if (o > 8388607) o = 8388607;
    if (o < -8388608) o = -8388608;
    return o;
  endfunction

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic model_step();
    int t;
    for (int c = 0; c < 2; c++) begin
      t = (c == 0) ? int'(att_l) : int'(att_r);
      if (cur_ref[c] == t) div_ref[c] = 0;
      else if (div_ref[c] + 1 >= (1 << glide_sel)) begin
        div_ref[c] = 0;
        cur_ref[c] += (cur_ref[c] < t) ? 1 : -1;
      end else div_ref[c]++;
    end
    if (soft_mute && m_ref > 0) m_ref--;
    else if (!soft_mute && m_ref < SPAN) m_ref++;
  endtask

  // one strobe: expected from pre-strobe state, sampled 3 clocks later
  task automatic send(input int l, input int r, input string tag);
    longint el, er;
    el = out_ref(l, cur_ref[0], m_ref);
    er = out_ref(r, cur_ref[1], m_ref);
    model_step();
    @(negedge clk);
    smp_stb = 1; smp_l_in = DATA_W'(l); smp_r_in = DATA_W'(r);
    @(negedge clk);
    smp_stb = 0;
    @(negedge clk);
    @(negedge clk);
    chk(smp_out_vld == 1'b1, {tag, " valid (R11)"}, smp_out_vld, 1);
    chk(longint'(smp_l_out) == el, {tag, " left"}, smp_l_out, el);
    chk(longint'(smp_r_out) == er, {tag, " right"}, smp_r_out, er);
    chk(mute_done == (m_ref == 0), {tag, " mute_done"}, mute_done, (m_ref == 0));
  endtask

  task automatic t_reset();
    chk(smp_l_out == 0 && smp_r_out == 0, "R1 outputs zero", smp_l_out, 0);
    chk(smp_out_vld == 0, "R1 valid low", smp_out_vld, 0);
    chk(mute_done == 0, "R1 done low", mute_done, 0);
    send(1000, -1000, "R1");
    chk(smp_l_out == 1000 && smp_r_out == -1000, "R1 unity", smp_l_out, 1000);
  endtask

  task automatic t_glide();
    glide_sel = 0; att_l = 8'hF0; att_r = 8'hFA;
    for (int i = 0; i < 20; i++) send(4000000 - i * 7, -3000001 + i, "R4");
  endtask

  task automatic t_gain_law();
    att_l = 8'h00; att_r = 8'hC0;
    for (int i = 0; i < 260; i++) send(8388607, -8388608 + i, "R2");
    send(8388607, -8388608, "R2");
    chk(smp_l_out == 0, "R2 code zero silent", smp_l_out, 0);
  endtask

  task automatic t_round();
    att_l = 8'hF3; att_r = 8'hE7;
    for (int i = 0; i < 260; i++) send(i * 3 + 1, -(i * 5 + 1), "R3");
    send(1, -1, "R3"); send(3, -3, "R3"); send(12345, -12345, "R3");
    send(8388607, -8388608, "R3");
  endtask

  task automatic t_speed();
    glide_sel = 3; att_l = 8'hF0;
    for (int i = 0; i < 30; i++) send(2000000, 2000000, "R5");
    glide_sel = 1; att_l = 8'hF8; att_r = 8'hEB;
    for (int i = 0; i < 20; i++) send(-2000000, 1500000, "R5");
  endtask

  task automatic t_retarget();
    glide_sel = 0; att_l = 8'h80;
    for (int i = 0; i < 10; i++) send(5000000, -5000000, "R6");
    att_l = 8'hFF;
    for (int i = 0; i < 140; i++) send(5000000, -5000000, "R6");
  endtask

  task automatic t_mute();
    att_l = 8'hFF; att_r = 8'hF0;
    soft_mute = 1;
    for (int i = 0; i < SPAN - 1; i++) send(7000000, -7000000, "R7");
    send(7000000, -7000000, "R8");  // count reaches zero here
    chk(mute_done == 1, "R8 done at end of ramp", mute_done, 1);
    send(7000000, -7000000, "R8");
    soft_mute = 0;
    send(7000000, -7000000, "R9");
    chk(mute_done == 0, "R9 done falls", mute_done, 0);
    for (int i = 0; i < SPAN; i++) send(7000000, -7000000, "R9");
  endtask

  task automatic t_reverse();
    soft_mute = 1;
    for (int i = 0; i < 3000; i++) send(-6000000, 6000000, "R10");
    soft_mute = 0;
    for (int i = 0; i < 3010; i++) send(-6000000, 6000000, "R10");
  endtask

  task automatic t_hold();
    logic signed [DATA_W-1:0] hl, hr;
    send(1234567, -7654321, "R11");
    hl = smp_l_out; hr = smp_r_out;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      chk(smp_out_vld == 0, "R11 no extra valid", smp_out_vld, 0);
      chk(smp_l_out == hl && smp_r_out == hr, "R11 hold", smp_l_out, hl);
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    cur_ref = '{255, 255}; div_ref = '{0, 0}; m_ref = SPAN;
    repeat (4) @(negedge clk);
    rst = 0;
    @(negedge clk);
    t_reset();
    t_glide();
    t_gain_law();
    t_round();
    t_speed();
    t_retarget();
    t_mute();
    t_reverse();
    t_hold();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule